// File: doc/BRIEF.md
# Peripheral Register Bank with Set and Clear Windows

This block holds a small bank of peripheral control registers of `DATA_W` bits each. Every register can be reached at three addresses that differ only in the window-select field. The normal window gives plain reads and full-word writes. A write through the set window turns on the bits that are 1 in the data. A write through the clear window turns off the bits that are 1 in the data. Each of these changes is applied at one clock edge and needs no read by the master, so it cannot be broken up by another master's access.

The bank has `NPORTS` independent request ports, each with valid/ready signalling and a registered response one cycle later. Requests on different ports that hit the same register in the same cycle merge under a fixed priority. A field update is done by the master as two separate writes: a clear of the field mask, then a set of the new value. Between the two writes the register holds an intermediate value, so the pair is not atomic. Masked reads are done by the master from a plain read.

Top module: `alias_reg_bank`

## Requirements
- R1: While reset is applied, and after it is released, every register reads 0 and no response is valid. `req_ready` is 0 during reset and becomes 1 a few cycles after release.
- R2: An accepted write through the normal window replaces the whole addressed register with the write data.
- R3: An accepted write through the set window makes new = old OR data.
- R4: An accepted write through the clear window makes new = old AND NOT data.
- R5: An accepted read through any of the three windows returns, in the cycle after acceptance, the register value from before any write accepted in the same cycle. A write response has `rsp_rdata` = 0.
- R6: Address decode works on byte addresses. Bits [WIN_LSB+1:WIN_LSB] select the window: 0 is normal, 1 is set, 2 is clear. Bits [WIN_LSB-1:2] give the register index. The set-window and clear-window addresses are therefore the window base plus the same offset as the normal-window address.
- R7: A request is in error if any of these holds: the window code is 3, the index is NREGS or more, bits [1:0] are not zero, or any bit above the window field is set. An erroring request responds with `rsp_err` = 1 and `rsp_rdata` = 0, and changes no register.
- R8: When several ports write the same register in one cycle, a normal-window write wins, and among several normal-window writes the lowest port index wins. With no normal-window write, all set masks and all clear masks are ORed together, and clear beats set on bits they share.
- R9: A field update written as a clear of mask M followed by a set of value V in the next cycle gives (old AND NOT M) OR V. A read between the two writes shows old AND NOT M.
- R10: A set-window or clear-window write with all-zero data leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release is synchronised inside the block. |
| req_valid | input | NPORTS | Request valid, one bit per port |
| req_write | input | NPORTS | 1 = write, 0 = read, one bit per port |
| req_addr | input | NPORTS*ADDR_W | Byte address per port; port p uses slice [p*ADDR_W +: ADDR_W] |
| req_wdata | input | NPORTS*DATA_W | Write data or mask per port |
| req_ready | output | 1 | Bank is ready to accept requests on all ports |
| rsp_valid | output | NPORTS | Response valid, one cycle after acceptance |
| rsp_err | output | NPORTS | The request was decoded as out of range |
| rsp_rdata | output | NPORTS*DATA_W | Read data per port; 0 for writes and errors |

## Verification
Every response is due exactly one clock edge after its request is accepted. The register change from a write is visible to a read accepted at the following edge. A read in the same cycle as the write still returns the old value. The bench drives stimulus on the falling edge. Its behavioural model predicts the response and the next register state for that cycle, and the bench compares all response outputs shortly after each rising edge, including cycles with no request. Field updates and same-cycle conflicts are placed on back-to-back edges, so the intermediate values and the merged results are checked in the exact cycles where they appear.

// File: rtl/ab_pkg.sv
package ab_pkg;
  // Window selector taken from the address field above the register offset.
  typedef enum logic [1:0] {
    WIN_PLAIN = 2'd0,
    WIN_SET   = 2'd1,
    WIN_CLR   = 2'd2,
    WIN_NONE  = 2'd3
  } win_e;
endpackage

// File: rtl/ab_decode.sv
module ab_decode #(
  parameter int ADDR_W  = 16,
  parameter int WIN_LSB = 12,
  parameter int NREGS   = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output ab_pkg::win_e      win,
  output logic [IDX_W-1:0]  idx,
  output logic              bad
);
  localparam int OFF_W = WIN_LSB - 2;
  localparam logic [OFF_W-1:0] LIMIT = OFF_W'(NREGS);

  logic [OFF_W-1:0] off;
  logic             high_bad;
  logic             align_bad;

  always_comb begin
    win       = ab_pkg::win_e'(addr[WIN_LSB+1:WIN_LSB]);
    off       = addr[WIN_LSB-1:2];
    high_bad  = |addr[ADDR_W-1:WIN_LSB+2];
    align_bad = |addr[1:0];
    bad       = high_bad | align_bad | (win == ab_pkg::WIN_NONE) | (off >= LIMIT);
    idx       = off[IDX_W-1:0];
  end
endmodule

// File: rtl/ab_reg_slice.sv
module ab_reg_slice #(
  parameter int          DATA_W = 32,
  parameter int          NPORTS = 2,
  parameter int          IDX_W  = 3,
  parameter int unsigned MY_IDX = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        wr_ok,
  input  logic [2*NPORTS-1:0]      win_flat,
  input  logic [NPORTS*IDX_W-1:0]  idx_flat,
  input  logic [NPORTS*DATA_W-1:0] wdata_flat,
  output logic [DATA_W-1:0]        q
);
  localparam logic [IDX_W-1:0] ME = IDX_W'(MY_IDX);

  logic              plain_any;
  logic [DATA_W-1:0] plain_val;
  logic [DATA_W-1:0] set_m;
  logic [DATA_W-1:0] clr_m;
  logic              en;
  logic [DATA_W-1:0] d;

  // Next-state: scan ports from high to low so the lowest plain writer wins.
  always_comb begin
    plain_any = 1'b0;
    plain_val = '0;
    set_m     = '0;
    clr_m     = '0;
    for (int p = NPORTS - 1; p >= 0; p--) begin
      if (wr_ok[p] && (idx_flat[p*IDX_W +: IDX_W] == ME)) begin
        case (ab_pkg::win_e'(win_flat[2*p +: 2]))
          ab_pkg::WIN_PLAIN: begin
            plain_any = 1'b1;
            plain_val = wdata_flat[p*DATA_W +: DATA_W];
          end
          ab_pkg::WIN_SET: set_m = set_m | wdata_flat[p*DATA_W +: DATA_W];
          ab_pkg::WIN_CLR: clr_m = clr_m | wdata_flat[p*DATA_W +: DATA_W];
          default: ;
        endcase
      end
    end
    en = plain_any | (|set_m) | (|clr_m);
    d  = plain_any ? plain_val : ((q | set_m) & ~clr_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/ab_resp.sv
module ab_resp #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc,
  input  logic                    wr,
  input  logic                    bad,
  input  logic [IDX_W-1:0]        idx,
  input  logic [NREGS*DATA_W-1:0] reg_flat,
  output logic                    rsp_valid,
  output logic                    rsp_err,
  output logic [DATA_W-1:0]       rsp_rdata
);
  logic [DATA_W-1:0] sel;
  logic              v_d;
  logic              e_d;
  logic [DATA_W-1:0] r_d;

  always_comb begin
    sel = '0;
    for (int k = 0; k < NREGS; k++) begin
      if (idx == IDX_W'(k)) sel = reg_flat[k*DATA_W +: DATA_W];
    end
    v_d = acc;
    e_d = acc & bad;
    r_d = (acc && !wr && !bad) ? sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= v_d;
      rsp_err   <= e_d;
      rsp_rdata <= r_d;
    end
  end
endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank #(
  parameter int NREGS   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  parameter int WIN_LSB = 12,
  parameter int NPORTS  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        req_valid,
  input  logic [NPORTS-1:0]        req_write,
  input  logic [NPORTS*ADDR_W-1:0] req_addr,
  input  logic [NPORTS*DATA_W-1:0] req_wdata,
  output logic                     req_ready,
  output logic [NPORTS-1:0]        rsp_valid,
  output logic [NPORTS-1:0]        rsp_err,
  output logic [NPORTS*DATA_W-1:0] rsp_rdata
);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic ready_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ready_q <= 1'b0;
    else             ready_q <= 1'b1;
  end
  assign req_ready = ready_q;

  logic [NPORTS-1:0]        acc;
  logic [NPORTS-1:0]        bad;
  logic [NPORTS-1:0]        wr_ok;
  logic [2*NPORTS-1:0]      win_flat;
  logic [NPORTS*IDX_W-1:0]  idx_flat;
  logic [NREGS*DATA_W-1:0]  reg_flat;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    ab_pkg::win_e win_p;

    ab_decode #(
      .ADDR_W (ADDR_W),
      .WIN_LSB(WIN_LSB),
      .NREGS  (NREGS),
      .IDX_W  (IDX_W)
    ) u_dec (
      .addr(req_addr[p*ADDR_W +: ADDR_W]),
      .win (win_p),
      .idx (idx_flat[p*IDX_W +: IDX_W]),
      .bad (bad[p])
    );

    assign win_flat[2*p +: 2] = win_p;
    assign acc[p]   = req_valid[p] & ready_q;
    assign wr_ok[p] = acc[p] & req_write[p] & ~bad[p];

    ab_resp #(
      .DATA_W(DATA_W),
      .NREGS (NREGS),
      .IDX_W (IDX_W)
    ) u_resp (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .acc      (acc[p]),
      .wr       (req_write[p]),
      .bad      (bad[p]),
      .idx      (idx_flat[p*IDX_W +: IDX_W]),
      .reg_flat (reg_flat),
      .rsp_valid(rsp_valid[p]),
      .rsp_err  (rsp_err[p]),
      .rsp_rdata(rsp_rdata[p*DATA_W +: DATA_W])
    );
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    ab_reg_slice #(
      .DATA_W(DATA_W),
      .NPORTS(NPORTS),
      .IDX_W (IDX_W),
      .MY_IDX(r)
    ) u_slice (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_ok     (wr_ok),
      .win_flat  (win_flat),
      .idx_flat  (idx_flat),
      .wdata_flat(req_wdata),
      .q         (reg_flat[r*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/ab_checker.sv
module ab_checker #(
  parameter int NREGS   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  parameter int WIN_LSB = 12,
  parameter int NPORTS  = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPORTS-1:0]        req_valid,
  input logic [NPORTS-1:0]        req_write,
  input logic [NPORTS*ADDR_W-1:0] req_addr,
  input logic [NPORTS*DATA_W-1:0] req_wdata,
  input logic                     req_ready,
  input logic [NPORTS-1:0]        rsp_valid,
  input logic [NPORTS-1:0]        rsp_err,
  input logic [NPORTS*DATA_W-1:0] rsp_rdata,
  input logic [NREGS*DATA_W-1:0]  reg_flat
);
  logic [NREGS-1:0]  pl;
  logic [NREGS-1:0]  st;
  logic [NREGS-1:0]  cl;
  logic [DATA_W-1:0] pv [NREGS];

  // Independent view of which register each accepted write targets.
  always_comb begin
    logic [ADDR_W-1:0] a;
    int k;
    for (int i = 0; i < NREGS; i++) begin
      pl[i] = 1'b0;
      st[i] = 1'b0;
      cl[i] = 1'b0;
      pv[i] = '0;
    end
    for (int p = 0; p < NPORTS; p++) begin
      a = req_addr[p*ADDR_W +: ADDR_W];
      k = int'(a[WIN_LSB-1:2]);
      if (req_valid[p] && req_ready && req_write[p] && (a[1:0] == 2'b00) &&
          (a[ADDR_W-1:WIN_LSB+2] == '0) && (k < NREGS)) begin
        case (a[WIN_LSB+1:WIN_LSB])
          2'd0: if (!pl[k]) begin
            pl[k] = 1'b1;
            pv[k] = req_wdata[p*DATA_W +: DATA_W];
          end
          2'd1: st[k] = 1'b1;
          2'd2: cl[k] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_rchk
    // R2: normal-window write lands whole (lowest port wins per R8)
    a_r2_plain_lands: assert property (@(posedge clk) disable iff (!rst_n)
      pl[i] |=> (reg_flat[i*DATA_W +: DATA_W] == $past(pv[i])));
    // R3: with only set traffic, no bit falls
    a_r3_set_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!pl[i] && !cl[i]) |=> (($past(reg_flat[i*DATA_W +: DATA_W]) &
                              ~reg_flat[i*DATA_W +: DATA_W]) == '0));
    // R4: with only clear traffic, no bit rises
    a_r4_clr_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!pl[i] && !st[i]) |=> ((reg_flat[i*DATA_W +: DATA_W] &
                              ~$past(reg_flat[i*DATA_W +: DATA_W])) == '0));
    // R7: a register no valid write targets holds its value
    a_r7_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!pl[i] && !st[i] && !cl[i]) |=> $stable(reg_flat[i*DATA_W +: DATA_W]));
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_pchk
    // R5: response exactly one cycle after acceptance
    a_r5_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rsp_valid[p] == $past(req_valid[p] && req_ready)));
    // R7: erroring response carries no data
    a_r7_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[p] && rsp_err[p]) |-> (rsp_rdata[p*DATA_W +: DATA_W] == '0));
  end
endmodule

bind alias_reg_bank ab_checker #(
  .NREGS  (NREGS),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .WIN_LSB(WIN_LSB),
  .NPORTS (NPORTS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err),
  .rsp_rdata(rsp_rdata),
  .reg_flat (reg_flat)
);

// File: tb/alias_reg_bank_tb.sv
module alias_reg_bank_tb;
  localparam int NR = 8;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int NP = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    req_valid = '0;
  logic [NP-1:0]    req_write = '0;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP*DW-1:0] req_wdata = '0;
  logic             req_ready;
  logic [NP-1:0]    rsp_valid;
  logic [NP-1:0]    rsp_err;
  logic [NP*DW-1:0] rsp_rdata;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [31:0] model [NR];

  always #5 clk = ~clk;

  alias_reg_bank #(.NREGS(NR), .DATA_W(DW), .ADDR_W(AW), .WIN_LSB(12), .NPORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

  // Address of register idx in window w: w=0 normal, 1 set, 2 clear (R6).
  function automatic logic [15:0] adr(int w, int idx);
    return 16'((w << 12) | (idx << 2));
  endfunction

  task automatic put(int p, bit w, logic [15:0] a, logic [31:0] d);
    req_valid[p] = 1'b1;
    req_write[p] = w;
    req_addr[p*AW +: AW] = a;
    req_wdata[p*DW +: DW] = d;
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Predict, clock, compare every output.
  task automatic step(string tag);
    bit          ev [NP];
    bit          ee [NP];
    logic [31:0] ed [NP];
    bit          pw [NR];
    logic [31:0] pvv [NR];
    logic [31:0] sm [NR];
    logic [31:0] cm [NR];
    for (int r = 0; r < NR; r++) begin
      pw[r] = 0; pvv[r] = 0; sm[r] = 0; cm[r] = 0;
    end
    for (int p = 0; p < NP; p++) begin
      logic [15:0] a;
      int w;
      int idx;
      bit bad;
      a = req_addr[p*AW +: AW];
      w = int'(a[13:12]);
      idx = int'(a[11:2]);
      bad = (a[15:14] != 0) || (a[1:0] != 0) || (w == 3) || (idx >= NR);
      ev[p] = req_valid[p];
      ee[p] = req_valid[p] && bad;
      ed[p] = (req_valid[p] && !req_write[p] && !bad) ? model[idx] : 32'h0;
      if (req_valid[p] && req_write[p] && !bad) begin
        if (w == 0 && !pw[idx]) begin pw[idx] = 1; pvv[idx] = req_wdata[p*DW +: DW]; end
        else if (w == 1) sm[idx] |= req_wdata[p*DW +: DW];
        else if (w == 2) cm[idx] |= req_wdata[p*DW +: DW];
      end
    end
    for (int r = 0; r < NR; r++)
      model[r] = pw[r] ? pvv[r] : ((model[r] | sm[r]) & ~cm[r]);
    @(posedge clk);
    #2;
    check(tag, "ready R1", {31'b0, req_ready}, 32'h1);
    for (int p = 0; p < NP; p++) begin
      check(tag, $sformatf("p%0d valid", p), {31'b0, rsp_valid[p]}, {31'b0, ev[p]});
      check(tag, $sformatf("p%0d err", p), {31'b0, rsp_err[p]}, {31'b0, ee[p]});
      check(tag, $sformatf("p%0d rdata", p), rsp_rdata[p*DW +: DW], ed[p]);
    end
    @(negedge clk);
    req_valid = '0;
    req_write = '0;
  endtask

  task automatic rd(string tag, int w, int idx);
    put(0, 1'b0, adr(w, idx), 32'h0);
    step(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < NR; r++) model[r] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "ready in reset", {31'b0, req_ready}, 32'h0);
    check("R1", "rsp_valid in reset", {30'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int r = 0; r < NR; r++) rd("R1", 0, r);

    // R2: full-word replace, read back through every window (R5, R6)
    put(0, 1'b1, adr(0, 3), 32'hA5A5_0F0F); step("R2");
    rd("R2", 0, 3);
    rd("R5", 1, 3);
    rd("R5", 2, 3);
    // R3: set
    put(0, 1'b1, adr(1, 3), 32'h0000_F0F0); step("R3");
    rd("R3", 0, 3);
    // R4: clear
    put(0, 1'b1, adr(2, 3), 32'hA500_000F); step("R4");
    rd("R4", 0, 3);
    // R10: zero masks
    put(0, 1'b1, adr(1, 3), 32'h0); step("R10");
    put(0, 1'b1, adr(2, 3), 32'h0); step("R10");
    rd("R10", 0, 3);
    // R5: read and write of the same register in one cycle returns old value
    put(0, 1'b0, adr(0, 3), 32'h0);
    put(1, 1'b1, adr(1, 3), 32'h0F00_0000); step("R5");
    rd("R5", 0, 3);

    // R8: conflicts
    put(0, 1'b1, adr(0, 5), 32'h0000_000F); step("R8");
    put(0, 1'b1, adr(1, 5), 32'h0000_FF00);
    put(1, 1'b1, adr(2, 5), 32'h0000_0FF0); step("R8");
    rd("R8", 0, 5);
    put(0, 1'b1, adr(1, 6), 32'hFFFF_FFFF);
    put(1, 1'b1, adr(0, 6), 32'h1234_5678); step("R8");
    rd("R8", 0, 6);
    put(0, 1'b1, adr(0, 4), 32'h0000_0011);
    put(1, 1'b1, adr(0, 4), 32'h0000_0022); step("R8");
    rd("R8", 0, 4);
    put(0, 1'b1, adr(1, 4), 32'h0000_0100);
    put(1, 1'b1, adr(1, 4), 32'h0001_0000); step("R8");
    rd("R8", 0, 4);

    // R9: field update in two writes, intermediate value visible
    put(0, 1'b1, adr(0, 2), 32'hFFFF_FFFF); step("R9");
    put(0, 1'b1, adr(2, 2), 32'h0000_0F00); step("R9");
    rd("R9", 0, 2);
    put(0, 1'b1, adr(1, 2), 32'h0000_0500); step("R9");
    rd("R9", 0, 2);

    // R6: computed window addresses for register 7
    put(0, 1'b1, adr(0, 7), 32'h00FF_00FF); step("R6");
    put(0, 1'b1, 16'h1000 + 16'h001C, 32'hF000_0000); step("R6");
    put(0, 1'b1, 16'h2000 + 16'h001C, 32'h0000_000F); step("R6");
    rd("R6", 0, 7);

    // R7: error cases leave state untouched
    put(0, 1'b1, 16'h300C, 32'hFFFF_FFFF); step("R7");
    put(0, 1'b1, 16'h000D, 32'hFFFF_FFFF); step("R7");
    put(0, 1'b1, 16'h0020, 32'hFFFF_FFFF); step("R7");
    put(0, 1'b1, 16'h400C, 32'hFFFF_FFFF); step("R7");
    put(0, 1'b0, 16'h0020, 32'h0); step("R7");
    rd("R7", 0, 3);

    // Mixed traffic on both ports (R2 R3 R4 R5 R7 R8)
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < NP; p++) begin
        if ($urandom % 4 != 0) begin
          int w;
          int idx;
          logic [15:0] a;
          w = ($urandom % 16 == 0) ? 3 : int'($urandom % 3);
          idx = int'($urandom % 10);
          a = adr(w, idx);
          if ($urandom % 20 == 0) a[0] = 1'b1;
          put(p, 1'($urandom % 2), a, $urandom);
        end
      end
      step("R8");
    end
    for (int r = 0; r < NR; r++) rd("R5", 0, r);

    finish_run();
  end
endmodule